// File: doc/BRIEF.md
# Two-Dimensional Box Copy Address Generator

This block turns a rectangular copy description into a stream of transfer beats. The source is read as rows of one fixed length, each row starting a fixed stride after the previous one. The destination is written as rows with their own length and stride. Both sides must carry the same number of bytes, so data can be regrouped, for example from many short rows into a few long ones. Each side can also be held at one fixed address, or read and written as one contiguous run even when a stride is configured.

A start pulse captures the configuration. The block then presents one read beat and one write beat for each chunk. Each beat has an address and a byte count, and the read and write channels each have a valid/ready handshake. A chunk is as long as the shorter of the bytes left in the current source row and the bytes left in the current destination row. The pattern can repeat for a programmed number of frames. After the final chunk, a one-cycle done pulse closes the transfer. If the configuration is inconsistent, the block raises an error flag instead of starting.

Top module: `box_dma_agu`

## Requirements
- R1: After reset, busy, done, cfg_err, rd_valid and wr_valid are all low.
- R2: A start pulse while idle with a legal configuration raises busy on the next cycle. A start pulse while busy is ignored, and the configuration applied at that moment has no effect on the beats.
- R3: Each beat's length equals the smaller of the bytes left in the current source row and in the current destination row. The read and write beats of a chunk carry the same length, and a beat never crosses a row boundary on either side.
- R4: With the source increment flag set, each source row starts `src_stride` bytes after the previous one when the source scatter flag is 1. It starts `src_len` bytes after the previous one (contiguous) when the scatter flag is 0. Beats inside a row advance by the bytes already moved in that row.
- R5: The destination side follows the same rules as R4, using its own `dst_len`, `dst_stride`, `dst_inc` and `dst_sg`.
- R6: With a side's increment flag at 0, every beat on that side carries that side's start address, and that side's stride is neither used nor checked.
- R7: The frame pattern repeats `frames` times back to back, with the row sequence continuing across frames. The bytes moved total frames × src_rows × src_len.
- R8: If a side has increment = 1 and scatter = 1 and its stride is less than or equal to its row length, a start sets cfg_err, and busy stays low with no beats.
- R9: If src_rows × src_len differs from dst_rows × dst_len, or the total is zero, or frames is zero, a start sets cfg_err, and busy stays low with no beats.
- R10: The read and write beats of a chunk are offered together. Each holds its address and length until it is accepted, and the next chunk is offered only after both have been accepted.
- R11: Done is high for exactly one cycle, the cycle after the last chunk's final acceptance. Busy falls in that same cycle.
- R12: cfg_err holds its value until the next start taken while idle. A legal start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, captures configuration |
| src_addr | input | AW | Source start address |
| src_len | input | LW | Source row length in bytes |
| src_stride | input | AW | Source row start-to-start distance |
| src_rows | input | CW | Source rows per frame |
| src_inc | input | 1 | Source address increments |
| src_sg | input | 1 | Source applies the row gap |
| dst_addr | input | AW | Destination start address |
| dst_len | input | LW | Destination row length in bytes |
| dst_stride | input | AW | Destination row start-to-start distance |
| dst_rows | input | CW | Destination rows per frame |
| dst_inc | input | 1 | Destination address increments |
| dst_sg | input | 1 | Destination applies the row gap |
| frames | input | CW | Number of frame repetitions |
| busy | output | 1 | Transfer in progress |
| cfg_err | output | 1 | Last start was rejected |
| rd_valid | output | 1 | Read beat offered |
| rd_ready | input | 1 | Read beat accepted |
| rd_addr | output | AW | Read beat address |
| rd_len | output | LW | Read beat byte count |
| wr_valid | output | 1 | Write beat offered |
| wr_ready | input | 1 | Write beat accepted |
| wr_addr | output | AW | Write beat address |
| wr_len | output | LW | Write beat byte count |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The bench builds the block with its defaults: 32-bit addresses, 16-bit row lengths and 16-bit row and frame counts. Because beats count chunks rather than bytes, row lengths of 30000 and 40000 bytes can be reached in a few cycles, which exercises the upper part of the length field and a 120000-byte total that only fits the wider remaining-byte counter. Random ready patterns on both channels exercise the case where one side is accepted well before the other. Short, misaligned rows move row boundaries on the two sides past each other.

// File: rtl/box_dma_agu.sv
module box_dma_agu #(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] src_addr,
  input  logic [LW-1:0] src_len,
  input  logic [AW-1:0] src_stride,
  input  logic [CW-1:0] src_rows,
  input  logic          src_inc,
  input  logic          src_sg,
  input  logic [AW-1:0] dst_addr,
  input  logic [LW-1:0] dst_len,
  input  logic [AW-1:0] dst_stride,
  input  logic [CW-1:0] dst_rows,
  input  logic          dst_inc,
  input  logic          dst_sg,
  input  logic [CW-1:0] frames,
  output logic          busy,
  output logic          cfg_err,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  output logic [LW-1:0] rd_len,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [LW-1:0] wr_len,
  output logic          done
);
  localparam int PW = CW + LW;
  localparam int TW = PW + CW;

  logic          busy_q, err_q, done_q, rd_tk, wr_tk;
  logic          s_inc, d_inc;
  logic [LW-1:0] s_len, d_len, s_off, d_off;
  logic [AW-1:0] s_step, d_step, s_base, d_base;
  logic [TW-1:0] rem;

  logic [PW-1:0] s_tot, d_tot;
  logic          s_gap_bad, d_gap_bad, bad;
  assign s_tot     = PW'(src_rows) * PW'(src_len);
  assign d_tot     = PW'(dst_rows) * PW'(dst_len);
  assign s_gap_bad = src_inc && src_sg && (src_stride <= AW'(src_len));
  assign d_gap_bad = dst_inc && dst_sg && (dst_stride <= AW'(dst_len));
  assign bad = s_gap_bad || d_gap_bad || (s_tot != d_tot) ||
               (s_tot == '0) || (frames == '0);

  logic [LW-1:0] s_left, d_left, blen;
  logic          rd_go, wr_go, fire, last;
  assign s_left = s_len - s_off;
  assign d_left = d_len - d_off;
  assign blen   = (s_left < d_left) ? s_left : d_left;

  assign rd_valid = busy_q && !rd_tk;
  assign wr_valid = busy_q && !wr_tk;
  assign rd_go    = rd_tk || (rd_valid && rd_ready);
  assign wr_go    = wr_tk || (wr_valid && wr_ready);
  assign fire     = busy_q && rd_go && wr_go;
  assign last     = fire && (rem == TW'(blen));

  assign rd_addr = s_inc ? s_base + AW'(s_off) : s_base;
  assign wr_addr = d_inc ? d_base + AW'(d_off) : d_base;
  assign rd_len  = blen;
  assign wr_len  = blen;
  assign busy    = busy_q;
  assign cfg_err = err_q;
  assign done    = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0; err_q <= 1'b0; done_q <= 1'b0;
      rd_tk  <= 1'b0; wr_tk <= 1'b0;
      s_inc  <= 1'b0; d_inc <= 1'b0;
      s_len  <= '0; d_len <= '0; s_off <= '0; d_off <= '0;
      s_step <= '0; d_step <= '0; s_base <= '0; d_base <= '0;
      rem    <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && start) begin
        err_q  <= bad;
        busy_q <= !bad;
        rd_tk  <= 1'b0;
        wr_tk  <= 1'b0;
        s_inc  <= src_inc;
        d_inc  <= dst_inc;
        s_len  <= src_len;
        d_len  <= dst_len;
        s_off  <= '0;
        d_off  <= '0;
        s_step <= src_sg ? src_stride : AW'(src_len);
        d_step <= dst_sg ? dst_stride : AW'(dst_len);
        s_base <= src_addr;
        d_base <= dst_addr;
        rem    <= TW'(s_tot) * TW'(frames);
      end else if (fire) begin
        rd_tk <= 1'b0;
        wr_tk <= 1'b0;
        rem   <= rem - TW'(blen);
        if (blen == s_left) begin
          s_off <= '0;
          if (s_inc) s_base <= s_base + s_step;
        end else begin
          s_off <= s_off + blen;
        end
        if (blen == d_left) begin
          d_off <= '0;
          if (d_inc) d_base <= d_base + d_step;
        end else begin
          d_off <= d_off + blen;
        end
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else begin
        if (rd_valid && rd_ready) rd_tk <= 1'b1;
        if (wr_valid && wr_ready) wr_tk <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/box_dma_agu_chk.sv
module box_dma_agu_chk #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          cfg_err,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [AW-1:0] rd_addr,
  input logic [LW-1:0] rd_len,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [LW-1:0] wr_len,
  input logic          done
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_valid && !wr_valid));
  a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr) && $stable(rd_len)));
  a_r10_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_len)));
  a_r3_len_match: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && wr_valid) |-> (rd_len == wr_len && rd_len != '0));
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r11_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  a_r8_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !busy);
endmodule

bind box_dma_agu box_dma_agu_chk #(.AW(AW), .LW(LW)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cfg_err(cfg_err),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_len(rd_len),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_len(wr_len),
  .done(done)
);

// File: tb/box_dma_agu_tb_top.sv
module box_dma_agu_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] src_addr = '0, src_stride = '0, dst_addr = '0, dst_stride = '0;
  logic [15:0] src_len = '0, dst_len = '0, src_rows = '0, dst_rows = '0, frames = '0;
  logic        src_inc = 1'b0, src_sg = 1'b0, dst_inc = 1'b0, dst_sg = 1'b0;
  logic        rd_ready = 1'b0, wr_ready = 1'b0;
  logic        busy, cfg_err, rd_valid, wr_valid, done;
  logic [31:0] rd_addr, wr_addr;
  logic [15:0] rd_len, wr_len;

  always #(CLK_P/2) clk = ~clk;

  box_dma_agu dut_i (.*);

  int n_cmp = 0, n_bad = 0;
  logic [47:0] rq[$], wq[$];
  bit m_busy = 0, m_err = 0, m_done = 0, m_rtk = 0, m_wtk = 0;
  longint moved = 0;

  task automatic chk(string tag, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit cfg_bad();
    longint st = longint'(src_rows) * src_len;
    longint dt = longint'(dst_rows) * dst_len;
    return (src_inc && src_sg && src_stride <= src_len) ||
           (dst_inc && dst_sg && dst_stride <= dst_len) ||
           st != dt || st == 0 || frames == 0;
  endfunction

  function automatic void build();
    longint tot = longint'(frames) * src_rows * src_len;
    longint pos = 0, so = 0, dof = 0, sr = 0, dr = 0, n;
    longint sstep = src_sg ? src_stride : src_len;
    longint dstep = dst_sg ? dst_stride : dst_len;
    logic [31:0] a;
    while (pos < tot) begin
      n = (src_len - so < dst_len - dof) ? src_len - so : dst_len - dof;
      a = src_inc ? 32'(src_addr + sr * sstep + so) : src_addr;
      rq.push_back({a, 16'(n)});
      a = dst_inc ? 32'(dst_addr + dr * dstep + dof) : dst_addr;
      wq.push_back({a, 16'(n)});
      so += n; dof += n; pos += n;
      if (so == src_len) begin so = 0; sr++; end
      if (dof == dst_len) begin dof = 0; dr++; end
    end
  endfunction

  task automatic step(bit st, bit rr, bit wr);
    bit ra, wa;
    @(negedge clk);
    chk("R2 busy", busy, m_busy);
    chk("R11 done", done, m_done);
    chk("R8 R9 R12 cfg_err", cfg_err, m_err);
    chk("R10 rd_valid", rd_valid, m_busy && !m_rtk);
    chk("R10 wr_valid", wr_valid, m_busy && !m_wtk);
    if (m_busy && !m_rtk) begin
      chk("R4 R6 rd_addr", rd_addr, rq[0][47:16]);
      chk("R3 rd_len", rd_len, rq[0][15:0]);
    end
    if (m_busy && !m_wtk) begin
      chk("R5 R6 wr_addr", wr_addr, wq[0][47:16]);
      chk("R3 wr_len", wr_len, wq[0][15:0]);
    end
    start = st; rd_ready = rr; wr_ready = wr;
    m_done = 0;
    if (m_busy) begin
      ra = !m_rtk && rr;
      wa = !m_wtk && wr;
      if ((m_rtk || ra) && (m_wtk || wa)) begin
        moved += rq[0][15:0];
        void'(rq.pop_front());
        void'(wq.pop_front());
        m_rtk = 0; m_wtk = 0;
        if (rq.size() == 0) begin m_busy = 0; m_done = 1; end
      end else begin
        if (ra) m_rtk = 1;
        if (wa) m_wtk = 1;
      end
    end else if (st) begin
      if (cfg_bad()) m_err = 1;
      else begin m_err = 0; m_busy = 1; moved = 0; build(); end
    end
  endtask

  task automatic cfg(logic [31:0] sa, logic [15:0] sl, logic [31:0] ss, logic [15:0] sr,
                     bit si, bit sg, logic [31:0] da, logic [15:0] dl, logic [31:0] ds,
                     logic [15:0] dr, bit di, bit dg, logic [15:0] fr);
    src_addr = sa; src_len = sl; src_stride = ss; src_rows = sr; src_inc = si; src_sg = sg;
    dst_addr = da; dst_len = dl; dst_stride = ds; dst_rows = dr; dst_inc = di; dst_sg = dg;
    frames = fr;
  endtask

  task automatic run(bit poke);
    longint total = longint'(frames) * src_rows * src_len;
    bit legal = !cfg_bad();
    int k = 0;
    step(1, $urandom % 4 != 0, $urandom % 4 != 0);
    while ((m_busy || k < 3) && k < 5000) begin
      if (poke && k == 4) begin
        cfg(32'h5, 16'd3, 32'd1, 16'd1, 1, 1, 32'h7, 16'd9, 32'd1, 16'd1, 1, 1, 16'd1);
        step(1, $urandom % 4 != 0, $urandom % 4 != 0);
      end else step(0, $urandom % 4 != 0, $urandom % 4 != 0);
      k++;
    end
    if (k >= 5000) begin n_bad++; $display("FAIL R11 watchdog: transfer never ended"); end
    if (legal) chk("R7 bytes moved", moved, total);
    step(0, 0, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog: run hung");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle after reset
    step(0, 1, 1);
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 cfg_err", cfg_err, 0);
    chk("R1 rd_valid", rd_valid, 0); chk("R1 wr_valid", wr_valid, 0);
    // four 16-byte rows at stride 32 into two 32-byte rows at stride 128
    cfg(32'h0, 16'd16, 32'd32, 16'd4, 1, 1, 32'h1000, 16'd32, 32'd128, 16'd2, 1, 1, 16'd1);
    run(0);
    // R7: three frames, misaligned row boundaries
    cfg(32'h200, 16'd24, 32'd100, 16'd2, 1, 1, 32'h8000, 16'd16, 32'd20, 16'd3, 1, 1, 16'd3);
    run(0);
    // R8: stride equal to row length with gap applied
    cfg(32'h0, 16'd16, 32'd16, 16'd2, 1, 1, 32'h0, 16'd32, 32'd64, 16'd1, 1, 1, 16'd1);
    run(0);
    // R12: legal start clears the error; R4 contiguous source, R6 fixed destination
    cfg(32'h40, 16'd12, 32'd4, 16'd3, 1, 0, 32'hF00, 16'd9, 32'd0, 16'd4, 0, 1, 16'd2);
    run(0);
    // R9: byte totals differ
    cfg(32'h0, 16'd16, 32'd32, 16'd3, 1, 1, 32'h0, 16'd32, 32'd64, 16'd2, 1, 1, 16'd1);
    run(0);
    // R9: zero frames
    cfg(32'h0, 16'd16, 32'd32, 16'd2, 1, 1, 32'h0, 16'd32, 32'd64, 16'd1, 1, 1, 16'd0);
    run(0);
    // R2: start during a transfer with a new configuration is ignored
    cfg(32'h100, 16'd8, 32'd40, 16'd6, 1, 1, 32'h3000, 16'd12, 32'd50, 16'd4, 1, 1, 16'd2);
    run(1);
    // R3 R5: long rows near the top of the length field, source fixed
    cfg(32'hFFFF0000, 16'd30000, 32'd40000, 16'd4, 0, 1, 32'hFFFE0000, 16'd40000, 32'd50000,
        16'd3, 1, 1, 16'd1);
    run(0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule